// File: doc/BRIEF.md
# BCH Sector Parity Encoder

This block computes the 182-bit parity of a binary BCH code for one 512-byte flash sector. The code corrects up to 14 bit errors. It is a shortened form of the length-8191 code over GF(2^13), and the field is built from x^13 + x^4 + x^3 + x + 1 (0x201B). The generator polynomial has degree 182. It is the product of the minimal polynomials of alpha, alpha^3, ..., alpha^27, and a constant function works it out at elaboration from the field definition. No table is written out by hand.

A sector is opened with a start pulse, and then one byte is offered per valid beat. Each byte is absorbed in a single cycle by an eight-step unrolled division register. The beat flagged as last closes the sector, and a one-cycle done strobe follows. For a read-back check, the stored parity is presented on a separate input, and a mismatch flag in the done cycle reports a damaged sector. Decoding and error location are not part of this block.

Top module: `bchSectorEncoder`

## Requirements
- R1: After reset, parityOut is all zero and parityDone and parityMismatch are low.
- R2: A start pulse with beatValid low clears parityOut to zero by the next cycle.
- R3: Each accepted beat divides by the generator polynomial, taking the byte most significant bit first. The divided polynomial is the data polynomial times x^182, and the divisor is the product of the minimal polynomials of alpha^1, alpha^3, ..., alpha^27 in GF(2^13) with primitive polynomial 0x201B. parityOut bit 181 holds the coefficient of x^181, and parityOut bit 0 holds the constant term.
- R4: A cycle with beatValid low leaves parityOut unchanged, whatever beatData and beatLast carry.
- R5: parityDone is high for exactly the cycle after an accepted beat that has beatLast set, and is low in every other cycle.
- R6: After the last beat, beats that arrive without a new start are ignored. parityOut stays stable and parityDone stays low.
- R7: A sector of 512 zero bytes yields all-zero parity, because the register starts cleared.
- R8: The 4278-bit codeword has alpha^1 through alpha^28 as roots. The first data byte's most significant bit is the highest-degree coefficient, and the parity follows the data as its low 182 coefficients.
- R9: In the done cycle, parityMismatch is high exactly when refParity differs from parityOut. It is low in every other cycle, so a stored parity that no longer matches a sector with one or two flipped bits is flagged.
- R10: When a start pulse and a valid beat arrive in the same cycle, that beat becomes the first byte of the new sector.
- R11: Parity is linear: the parity of the XOR of two sectors equals the XOR of their parities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secStart | input | 1 | Opens a sector and clears the division register |
| beatValid | input | 1 | beatData carries a byte in this cycle |
| beatData | input | 8 | Sector byte, most significant bit processed first |
| beatLast | input | 1 | Marks the final byte of the sector |
| refParity | input | 182 | Stored parity to compare against |
| parityOut | output | 182 | Division remainder; bit 181 is the x^181 coefficient |
| parityDone | output | 1 | One-cycle strobe after the last beat |
| parityMismatch | output | 1 | In the done cycle, refParity differs from parityOut |

## Verification
The hardest case to reach from the ports is a start that lands on the same edge as a valid beat. In that case the clear and the first absorption merge, and a wrong priority would silently fold the old remainder into the new sector. The stimulus sends one random sector twice, once with a separate start and once with the start merged into the first beat, and requires equal parities. Idle gaps carry junk data and a false last flag to probe R4. The generator is also checked without reference to the division: the full codeword is evaluated at alpha^1 through alpha^28 with log tables built in the bench.

// File: rtl/bchCodePkg.sv
package bchCodePkg;
  localparam int GF_M    = 13;
  localparam int CORR_T  = 14;
  localparam int PAR_W   = GF_M * CORR_T;
  localparam int FIELD_N = (1 << GF_M) - 1;
  localparam logic [GF_M:0] PRIM_POLY = 14'h201B;

  typedef logic [GF_M-1:0]  gfElem_t;
  typedef logic [PAR_W-1:0] parity_t;

  typedef struct packed {
    logic clrState;
    logic takeBeat;
    logic endSector;
  } ctrlStrobe_t;

  // multiply two field elements, reducing by the primitive polynomial
  function automatic gfElem_t gfMul(gfElem_t a, gfElem_t b);
    gfElem_t prod = '0;
    gfElem_t aa = a;
    for (int i = 0; i < GF_M; i++) begin
      if (b[i]) prod = prod ^ aa;
      if (aa[GF_M-1]) aa = {aa[GF_M-2:0], 1'b0} ^ PRIM_POLY[GF_M-1:0];
      else            aa = {aa[GF_M-2:0], 1'b0};
    end
    return prod;
  endfunction

  // alpha raised to a non-negative exponent below 2^GF_M
  function automatic gfElem_t gfPow(int e);
    gfElem_t r = gfElem_t'(1);
    gfElem_t b = gfElem_t'(2);
    for (int i = 0; i < GF_M; i++) begin
      if (((e >> i) & 1) == 1) r = gfMul(r, b);
      b = gfMul(b, b);
    end
    return r;
  endfunction

  // binary minimal polynomial of alpha^e, product over its conjugates
  function automatic logic [GF_M:0] minPolyBits(int e);
    gfElem_t coef [GF_M+1];
    logic [GF_M:0] bits;
    gfElem_t root;
    int pw;
    for (int k = 0; k <= GF_M; k++) coef[k] = '0;
    coef[0] = gfElem_t'(1);
    pw = e;
    for (int j = 0; j < GF_M; j++) begin
      root = gfPow(pw);
      for (int k = j + 1; k >= 1; k--) coef[k] = coef[k-1] ^ gfMul(coef[k], root);
      coef[0] = gfMul(coef[0], root);
      pw = (pw * 2) % FIELD_N;
    end
    for (int k = 0; k <= GF_M; k++) bits[k] = coef[k][0];
    return bits;
  endfunction

  // generator: product of minimal polynomials of alpha^1, alpha^3, ...
  function automatic logic [PAR_W:0] genPoly();
    logic [PAR_W:0] acc;
    logic [PAR_W:0] nxt;
    logic [GF_M:0]  mb;
    acc = '0;
    acc[0] = 1'b1;
    for (int t = 0; t < CORR_T; t++) begin
      mb  = minPolyBits(2 * t + 1);
      nxt = '0;
      for (int k = 0; k <= GF_M; k++)
        if (mb[k]) nxt = nxt ^ (acc << k);
      acc = nxt;
    end
    return acc;
  endfunction
endpackage

// File: rtl/bchCtrl.sv
module bchCtrl
  import bchCodePkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        secStart,
  input  logic        beatValid,
  input  logic        beatLast,
  output ctrlStrobe_t strobe,
  output logic        doneQ
);
  logic activeQ;

  always_comb begin
    strobe.clrState  = secStart;
    strobe.takeBeat  = beatValid && (activeQ || secStart);
    strobe.endSector = strobe.takeBeat && beatLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= strobe.endSector;
      if (strobe.endSector)   activeQ <= 1'b0;
      else if (secStart)      activeQ <= 1'b1;
    end
  end
endmodule

// File: rtl/bchDatapath.sv
module bchDatapath
  import bchCodePkg::*;
#(
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              doneIn,
  input  logic [BEAT_W-1:0] beatData,
  input  parity_t           refParity,
  output parity_t           parityQ,
  output logic              mismatch
);
  localparam logic [PAR_W:0] GEN_FULL = genPoly();
  localparam parity_t        GEN_LOW  = GEN_FULL[PAR_W-1:0];

  parity_t stage [BEAT_W+1];

  assign stage[0] = strobe.clrState ? '0 : parityQ;

  for (genvar i = 0; i < BEAT_W; i++) begin : g_bitStep
    logic fb;
    assign fb = beatData[BEAT_W-1-i] ^ stage[i][PAR_W-1];
    assign stage[i+1] = {stage[i][PAR_W-2:0], 1'b0} ^ (fb ? GEN_LOW : '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                parityQ <= '0;
    else if (strobe.takeBeat) parityQ <= stage[BEAT_W];
    else if (strobe.clrState) parityQ <= '0;
  end

  assign mismatch = doneIn && (parityQ != refParity);
endmodule

// File: rtl/bchSectorEncoder.sv
module bchSectorEncoder
  import bchCodePkg::*;
#(
  parameter int BEAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              secStart,
  input  logic              beatValid,
  input  logic [BEAT_W-1:0] beatData,
  input  logic              beatLast,
  input  logic [PAR_W-1:0]  refParity,
  output logic [PAR_W-1:0]  parityOut,
  output logic              parityDone,
  output logic              parityMismatch
);
  ctrlStrobe_t strobe;

  bchCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .secStart(secStart), .beatValid(beatValid),
    .beatLast(beatLast), .strobe(strobe), .doneQ(parityDone)
  );

  bchDatapath #(.BEAT_W(BEAT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .doneIn(parityDone),
    .beatData(beatData), .refParity(refParity), .parityQ(parityOut),
    .mismatch(parityMismatch)
  );
endmodule

// File: rtl/bchSectorEncoder_chk.sv
module bchSectorEncoder_chk
  import bchCodePkg::*;
#(
  parameter int BEAT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              secStart,
  input logic              beatValid,
  input logic [BEAT_W-1:0] beatData,
  input logic              beatLast,
  input logic [PAR_W-1:0]  refParity,
  input logic [PAR_W-1:0]  parityOut,
  input logic              parityDone,
  input logic              parityMismatch
);
  // R2: a lone start empties the register
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (secStart && !beatValid) |=> (parityOut == '0));

  // R4: idle cycles hold the remainder
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!beatValid && !secStart) |=> $stable(parityOut));

  // R5: done only follows a beat carrying the last flag
  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityDone) |-> $past(beatValid && beatLast));

  // R9: mismatch is confined to the done cycle
  p_mismatch_in_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    parityMismatch |-> parityDone);

  // R1: outputs quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!parityDone && parityOut == '0));
endmodule

bind bchSectorEncoder bchSectorEncoder_chk #(.BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/sim_bchSectorEncoder.sv
module sim_bchSectorEncoder;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rstN = 1'b0;
  logic         secStart = 1'b0;
  logic         beatValid = 1'b0;
  logic [7:0]   beatData = '0;
  logic         beatLast = 1'b0;
  logic [181:0] refParity = '0;
  logic [181:0] parityOut;
  logic         parityDone;
  logic         parityMismatch;

  bchSectorEncoder u0 (.*);

  int checks = 0;
  int errors = 0;

  int expT [8191];
  int logT [8192];
  logic [182:0] gB;
  logic [7:0]   sec [512];
  logic [181:0] mPar;
  logic         mActive, mDone;
  logic [181:0] lastPar, pA, pB;
  logic         lastMis;

  task automatic chk(input bit ok, input string req, input logic [181:0] act, input logic [181:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int gmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return expT[(logT[a] + logT[b]) % 8191];
  endfunction

  function automatic logic [13:0] benchMinPoly(int e);
    int c [14];
    int pw;
    int root;
    logic [13:0] r;
    foreach (c[k]) c[k] = 0;
    c[0] = 1;
    pw = e;
    for (int j = 0; j < 13; j++) begin
      root = expT[pw];
      for (int k = j + 1; k >= 1; k--) c[k] = c[k-1] ^ gmul(c[k], root);
      c[0] = gmul(c[0], root);
      pw = (pw * 2) % 8191;
    end
    for (int k = 0; k < 14; k++) r[k] = c[k][0];
    return r;
  endfunction

  initial begin
    int v;
    logic [13:0] mb;
    logic [182:0] nxt;
    v = 1;
    for (int i = 0; i < 8191; i++) begin
      expT[i] = v;
      logT[v] = i;
      v = v << 1;
      if ((v & 'h2000) != 0) v = v ^ 'h201B;
    end
    gB = 183'd1;
    for (int t = 0; t < 14; t++) begin
      mb = benchMinPoly(2 * t + 1);
      nxt = '0;
      for (int k = 0; k < 14; k++) if (mb[k]) nxt = nxt ^ (gB << k);
      gB = nxt;
    end
  end

  // behavioural bit-serial division model, updated every edge
  always @(posedge clk) begin
    if (!rstN) begin
      mPar = '0; mActive = 1'b0; mDone = 1'b0;
    end else begin
      mDone = 1'b0;
      if (secStart) begin mPar = '0; mActive = 1'b1; end
      if (beatValid && mActive) begin
        for (int b = 7; b >= 0; b--) begin
          logic fb;
          fb = beatData[b] ^ mPar[181];
          mPar = {mPar[180:0], 1'b0};
          if (fb) mPar = mPar ^ gB[181:0];
        end
        if (beatLast) begin mActive = 1'b0; mDone = 1'b1; end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk(parityOut == mPar, "R3 parity", parityOut, mPar);
      chk(parityDone == mDone, "R5 done", 182'(parityDone), 182'(mDone));
      chk(parityMismatch == (mDone && (refParity != mPar)), "R9 mismatch",
          182'(parityMismatch), 182'(mDone && (refParity != mPar)));
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic sendSector(input bit merged, input bit gaps);
    logic [181:0] snap;
    if (!merged) begin
      secStart = 1'b1; beatValid = 1'b0; step(); secStart = 1'b0;
    end
    for (int i = 0; i < 512; i++) begin
      if (gaps && (i % 97) == 40) begin
        snap = parityOut;
        beatValid = 1'b0; beatLast = 1'b1;
        for (int g = 0; g < 3; g++) begin beatData = 8'($urandom); step(); end
        chk(parityOut == snap, "R4 idle hold", parityOut, snap);
      end
      beatValid = 1'b1; beatData = sec[i]; beatLast = (i == 511);
      secStart = merged && (i == 0);
      step();
    end
    secStart = 1'b0; beatValid = 1'b0; beatLast = 1'b0;
    lastPar = parityOut;
    lastMis = parityMismatch;
    step();
  endtask

  task automatic syndromeCheck();
    for (int r = 1; r <= 28; r++) begin
      int s;
      s = 0;
      for (int i = 0; i < 512; i++)
        for (int b = 7; b >= 0; b--) s = gmul(s, expT[r]) ^ int'(sec[i][b]);
      for (int k = 181; k >= 0; k--) s = gmul(s, expT[r]) ^ int'(lastPar[k]);
      chk(s == 0, "R8 codeword root", 182'(s), '0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] secA [512];
    logic [7:0] secB [512];
    logic [181:0] snap;
    repeat (4) step();
    rstN = 1'b1;
    @(negedge clk);
    chk(parityOut == '0 && !parityDone && !parityMismatch, "R1 reset state",
        parityOut, '0);
    step();

    // R7 all-zero sector
    foreach (sec[i]) sec[i] = 8'h00;
    sendSector(1'b0, 1'b0);
    chk(lastPar == '0, "R7 zero sector", lastPar, '0);

    // all-0xFF sector with idle gaps
    foreach (sec[i]) sec[i] = 8'hFF;
    sendSector(1'b0, 1'b1);
    syndromeCheck();

    // random A, separate start, then merged start (R10)
    foreach (sec[i]) begin sec[i] = 8'($urandom); secA[i] = sec[i]; end
    sendSector(1'b0, 1'b1);
    pA = lastPar;
    syndromeCheck();
    sendSector(1'b1, 1'b0);
    chk(lastPar == pA, "R10 merged start", lastPar, pA);

    // R11 linearity
    foreach (sec[i]) begin sec[i] = 8'($urandom); secB[i] = sec[i]; end
    sendSector(1'b0, 1'b0);
    pB = lastPar;
    syndromeCheck();
    foreach (sec[i]) sec[i] = secA[i] ^ secB[i];
    sendSector(1'b1, 1'b0);
    chk(lastPar == (pA ^ pB), "R11 linearity", lastPar, pA ^ pB);

    // R6 beats after the last without a start
    snap = parityOut;
    for (int i = 0; i < 5; i++) begin
      beatValid = 1'b1; beatData = 8'($urandom); beatLast = (i == 4); step();
    end
    beatValid = 1'b0; beatLast = 1'b0;
    chk(parityOut == snap && !parityDone, "R6 ignored without start", parityOut, snap);
    step();
    chk(parityOut == snap && !parityDone, "R6 no late done", parityOut, snap);

    // R9 stored parity compare
    refParity = pA;
    foreach (sec[i]) sec[i] = secA[i];
    sendSector(1'b0, 1'b0);
    chk(lastMis == 1'b0, "R9 intact sector", 182'(lastMis), 182'(0));
    sec[100] = sec[100] ^ 8'h10;
    sendSector(1'b0, 1'b0);
    chk(lastMis == 1'b1, "R9 single flip", 182'(lastMis), 182'(1));
    sec[377] = sec[377] ^ 8'h01;
    sendSector(1'b1, 1'b0);
    chk(lastMis == 1'b1, "R9 double flip", 182'(lastMis), 182'(1));

    // R2 lone start clears
    secStart = 1'b1; step(); secStart = 1'b0;
    chk(parityOut == '0, "R2 start clears", parityOut, '0);
    step();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule